// File: doc/BRIEF.md
# Banked GPIO Port Register Block

This block is a memory-mapped general-purpose I/O controller. The lines are grouped into banks of eight. Each bank owns two 32-bit registers: one holds the output values and one holds the per-line direction. A simple single-cycle register bus reaches these registers. It carries a read strobe, a write strobe, a word-aligned byte address and 32-bit write data. The block drives the pin output values and the output enables from its registers. It also synchronizes the pin inputs so that software can read them back.

The bank registers are not placed at linear addresses. Bank pairs start at byte 0x08 and sit eight bytes apart. The 16-byte window at 0x90..0x9F is reserved for an interrupt unit, so any bank that would land inside it is moved up past the window. The four word addresses of that window are only decoded here. The access is passed to a separate interrupt unit through a small forwarding port, and that unit's read data is returned on the bus. The number of banks is a parameter.

Top module: `gpio_bank_regs`

## Requirements
- R1: Bank n's registers begin at byte offset (n+1)*8. When that value is 0x90 or more, 0x10 is added to it, so bank 17 sits at 0xA0. Within a bank, +0x0 is the data register and +0x4 is the direction register. Only bits 7:0 are used, and address bits 1:0 are ignored.
- R2: A direction bit of 1 makes its line an input, and 1 is the reset value. A direction bit of 0 makes it an output. pin_oe is the inverse of the direction bit and pin_out is the data latch bit.
- R3: Line k belongs to bank k/8, bit k%8. It appears as bit k of pin_in, pin_out and pin_oe.
- R4: Byte offsets 0x90, 0x94, 0x98 and 0x9C are forwarded to the interrupt unit. irq_wr or irq_rd is raised for that cycle, irq_sel carries address bits 3:2 and irq_wdata carries the bus write data. A read there returns irq_rdata. These accesses change no bank register.
- R5: A write to a data register stores its value whether the lines are inputs or outputs. The latch holds that value until the next write to it, so the output value can be set up before the line is switched to output.
- R6: A data register read returns, for each bit, the synchronized pin level if that line is an input and the data latch if it is an output.
- R7: Reads of unmapped offsets return 0 and writes to them have no effect. Unmapped offsets are 0x00, 0x04 and every pair beyond the last bank.
- R8: Pin inputs pass through two flip-flops before the read mux. A pin change made just before clock edge e is returned by a read issued in the cycle after edge e+1, and not by the two reads before it.
- R9: After reset, every direction bit is 1, every data latch is 0, pin_oe and pin_out are all 0, and bus_rdata is 0.
- R10: bus_rdata is loaded on the clock edge that ends a read cycle and holds its value otherwise. Bits 31:8 are 0 for bank registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_wr | output | 1 | Write forwarded to the interrupt unit |
| irq_rd | output | 1 | Read forwarded to the interrupt unit |
| irq_sel | output | 2 | Interrupt register select (address bits 3:2) |
| irq_wdata | output | 32 | Forwarded write data |
| irq_rdata | input | 32 | Interrupt unit read data for the selected register |
| pin_in | input | NUM_BANKS*8 | Pin input levels |
| pin_out | output | NUM_BANKS*8 | Pin output values |
| pin_oe | output | NUM_BANKS*8 | Pin output enables |

## Verification
A register write shows on pin_out and pin_oe one edge after the write cycle. A read shows on bus_rdata one edge after the read cycle. The forwarding strobes are combinational in the access cycle. A pin change reaches read data only after the two synchronizer stages plus the read register. The bench therefore drives every access at a falling edge and samples at the next falling edge. It leaves at least three idle cycles after each random pin change before any read that depends on the pins. A directed sequence issues three back-to-back reads right after a pin change and expects the old, old, new pattern of R8.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned LINES_PER_BANK = 8;
  localparam int unsigned BUS_W          = 32;
  // reserved interrupt window, in 8-byte slots: 0x90 >> 3 and two slots wide
  localparam int unsigned WIN_SLOT_LO    = 'h12;
  localparam int unsigned WIN_SLOTS      = 2;

  typedef struct packed {
    logic       bank_hit;
    logic       is_dir;
    logic       win_hit;
    logic [1:0] win_sel;
  } gpio_dec_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 18,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_dec_t         dec,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] raw;
  logic              raw_ok;
  logic              unused_lsb;

  assign slot       = addr[ADDR_W-1:3];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    dec    = '0;
    raw    = '0;
    raw_ok = 1'b0;
    if (slot >= SLOT_W'(WIN_SLOT_LO) && slot < SLOT_W'(WIN_SLOT_LO + WIN_SLOTS)) begin
      dec.win_hit = 1'b1;
      dec.win_sel = addr[3:2];
    end else if (slot >= SLOT_W'(WIN_SLOT_LO + WIN_SLOTS)) begin
      raw    = slot - SLOT_W'(WIN_SLOTS + 1);
      raw_ok = 1'b1;
    end else if (slot != '0) begin
      raw    = slot - SLOT_W'(1);
      raw_ok = 1'b1;
    end
    dec.bank_hit = raw_ok && (raw < SLOT_W'(NUM_BANKS));
    dec.is_dir   = addr[2];
    idx          = raw[IDX_W-1:0];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_mix
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '1;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  // input lines read the pin, output lines read the latch
  assign rd_mix = (dir_q & pin_sync) | (~dir_q & data_q);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_data |=> $stable(data_q));

  // R5
  input_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && (dir_q == '1)) |=> (data_q == $past(wdata)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 18,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 irq_wr,
  output logic                 irq_rd,
  output logic [1:0]           irq_sel,
  output logic [BUS_W-1:0]     irq_wdata,
  input  logic [BUS_W-1:0]     irq_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe
);
  localparam int unsigned LPB   = LINES_PER_BANK;
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  gpio_dec_t              dec;
  logic [IDX_W-1:0]       idx;
  logic [NUM_LINES-1:0]   pin_sync;
  logic [LPB-1:0]         data_arr [NUM_BANKS];
  logic [LPB-1:0]         dir_arr  [NUM_BANKS];
  logic [LPB-1:0]         mix_arr  [NUM_BANKS];
  logic [BUS_W-1:0]       rd_next;

  gpio_sync2 #(.W(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr (bus_addr),
    .dec  (dec),
    .idx  (idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = bus_wr && dec.bank_hit && (idx == IDX_W'(b));

    gpio_bank #(.W(LPB)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_data  (sel && !dec.is_dir),
      .wr_dir   (sel && dec.is_dir),
      .wdata    (bus_wdata[LPB-1:0]),
      .pin_sync (pin_sync[b*LPB +: LPB]),
      .data_q   (data_arr[b]),
      .dir_q    (dir_arr[b]),
      .rd_mix   (mix_arr[b])
    );

    assign pin_out[b*LPB +: LPB] = data_arr[b];
    assign pin_oe[b*LPB +: LPB]  = ~dir_arr[b];
  end

  assign irq_wr    = bus_wr && dec.win_hit;
  assign irq_rd    = bus_rd && dec.win_hit;
  assign irq_sel   = dec.win_sel;
  assign irq_wdata = bus_wdata;

  always_comb begin
    rd_next = '0;
    if (dec.win_hit) begin
      rd_next = irq_rdata;
    end else if (dec.bank_hit) begin
      rd_next[LPB-1:0] = dec.is_dir ? dir_arr[idx] : mix_arr[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R7
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dec.bank_hit && !dec.win_hit) |=> (bus_rdata == '0));

  // R4
  irq_wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wr |-> (bus_wr && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'('h9))));

  // R4
  win_no_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec.win_hit) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec.bank_hit) |=> (bus_rdata[BUS_W-1:LPB] == '0));
endmodule

// File: tb/gpio_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb;
  localparam int NB = 18;
  localparam int AW = 12;
  localparam int NL = NB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_wr, irq_rd;
  logic [1:0]    irq_sel;
  logic [31:0]   irq_wdata;
  logic [31:0]   irq_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;

  int checks = 0;
  int failures = 0;
  int wr_seen = 0;
  logic [1:0]  cap_sel = '0;
  logic [31:0] cap_data = '0;
  logic [7:0]  m_data [NB];
  logic [7:0]  m_dir  [NB];

  always #2.5 clk = ~clk;

  // interrupt unit model: fixed pattern tagged with the selected register
  assign irq_rdata = 32'hA5A5_0000 | {30'd0, irq_sel};

  always @(posedge clk) begin
    if (irq_wr) begin
      wr_seen  <= wr_seen + 1;
      cap_sel  <= irq_sel;
      cap_data <= irq_wdata;
    end
  end

  gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_wr(irq_wr), .irq_rd(irq_rd), .irq_sel(irq_sel),
    .irq_wdata(irq_wdata), .irq_rdata(irq_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int base_of(int n);
    int r = (n + 1) * 8;
    if (r >= 'h90) r = r + 'h10;
    return r;
  endfunction

  function automatic logic [NL-1:0] model_out();
    logic [NL-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = m_data[b];
    return v;
  endfunction

  function automatic logic [NL-1:0] model_oe();
    logic [NL-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = ~m_dir[b];
    return v;
  endfunction

  function automatic logic [31:0] exp_data_rd(int b);
    logic [7:0] p = pin_in[b*8 +: 8];
    return {24'd0, (m_dir[b] & p) | (~m_dir[b] & m_data[b])};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_w(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus tasks start and end on a falling edge
  task automatic wr(int addr, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wr_bank(int b, bit is_dir, logic [7:0] v);
    wr(base_of(b) + (is_dir ? 4 : 0), {24'hDEAD00, v});
    if (is_dir) m_dir[b] = v; else m_data[b] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r, r2, r3;
    int w0;
    void'($urandom(32'd20240607));
    for (int b = 0; b < NB; b++) begin m_data[b] = 8'h00; m_dir[b] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk("R9 rdata", bus_rdata, 32'h0);
    chk_w("R9 pin_oe", pin_oe, '0);
    chk_w("R9 pin_out", pin_out, '0);
    rd(base_of(0) + 4, r);
    chk("R9 R1 dir reset", r, 32'h0000_00FF);

    // R1 R3 bank past the window lives at 0xA0
    wr_bank(17, 1'b1, 8'h00);
    chk("R1 R3 bank17 oe", 32'(pin_oe[143:136]), 32'h0000_00FF);
    wr_bank(17, 1'b0, 8'h3C);
    chk("R1 R2 bank17 out", 32'(pin_out[143:136]), 32'h0000_003C);
    rd('hA4, r);
    chk("R1 bank17 dir rd", r, 32'h0);
    rd('h88, r);
    chk("R1 bank16 dir at 0x88 via data", r, 32'h0);

    // R4 interrupt window forwarding
    w0 = wr_seen;
    wr('h94, 32'h1234_5678);
    @(posedge clk); #1;
    chk("R4 irq_wr count", 32'(wr_seen - w0), 32'd1);
    chk("R4 irq_sel", 32'(cap_sel), 32'd1);
    chk("R4 irq_wdata", cap_data, 32'h1234_5678);
    @(negedge clk);
    chk_w("R4 no bank change out", pin_out, model_out());
    chk_w("R4 no bank change oe", pin_oe, model_oe());
    rd('h9C, r);
    chk("R4 irq read", r, 32'hA5A5_0003);
    rd('h90, r);
    chk("R4 irq read sel0", r, 32'hA5A5_0000);

    // R7 unmapped offsets
    wr('h00, 32'hFFFF_FFFF);
    wr('h04, 32'h0000_0000);
    wr('hA8, 32'hFFFF_FFFF);
    wr('hAC, 32'h0000_0000);
    chk_w("R7 writes ignored out", pin_out, model_out());
    chk_w("R7 writes ignored oe", pin_oe, model_oe());
    rd('h04, r);
    chk("R7 read 0x04", r, 32'h0);
    rd('hAC, r);
    chk("R7 read past last bank", r, 32'h0);

    // R5 preload while input, then switch to output
    wr_bank(2, 1'b0, 8'h5A);
    chk("R5 latch while input oe", 32'(pin_oe[23:16]), 32'h0);
    rd(base_of(2) + 4, r);
    chk("R5 dir still input", r, 32'h0000_00FF);
    wr_bank(2, 1'b1, 8'h00);
    chk("R5 out after switch", 32'(pin_out[23:16]), 32'h0000_005A);
    chk("R5 oe after switch", 32'(pin_oe[23:16]), 32'h0000_00FF);

    // R6 mixed directions in one bank
    wr_bank(3, 1'b0, 8'h0F);
    wr_bank(3, 1'b1, 8'hF0);
    pin_in[31:24] = 8'hA5;
    idle(3);
    rd(base_of(3), r);
    chk("R6 mixed read", r, 32'h0000_00AF);

    // R8 synchronizer latency: old, old, new
    pin_in[7:0] = 8'h00;
    idle(3);
    pin_in[7:0] = 8'hFF;
    rd(base_of(0), r);
    rd(base_of(0), r2);
    rd(base_of(0), r3);
    chk("R8 first read old", r, 32'h0);
    chk("R8 second read old", r2, 32'h0);
    chk("R8 third read new", r3, 32'h0000_00FF);

    // R3 line 45 -> bank 5 bit 5
    wr_bank(5, 1'b0, 8'h20);
    wr_bank(5, 1'b1, 8'hDF);
    chk("R3 line45 oe", 32'(pin_oe[47:40]), 32'h0000_0020);
    chk("R3 line45 out", 32'(pin_out[45]), 32'h1);

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      int b = int'($urandom_range(NB - 1));
      bit d = 1'($urandom);
      wr_bank(b, d, 8'($urandom));
      for (int j = 0; j < NB; j++) pin_in[j*8 +: 8] = 8'($urandom);
      idle(3);
      chk_w("R2 R3 random out", pin_out, model_out());
      chk_w("R2 random oe", pin_oe, model_oe());
      b = int'($urandom_range(NB - 1));
      rd(base_of(b), r);
      chk("R6 R1 random data rd", r, exp_data_rd(b));
      rd(base_of(b) + 4, r);
      chk("R1 R10 random dir rd", r, {24'd0, m_dir[b]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule